// File: doc/BRIEF.md
# I2C Status and Interrupt Flag Register

This block keeps the byte-wide status word of an I2C controller and produces that controller's single interrupt request. The shifter, the address comparator and the arbitration logic report what happened on the bus as one-cycle event strobes. The block turns those strobes into sticky flags. Each flag has its own rule for being cleared: a write of the data register, a read of the data register, a read of the status register, or turning the controller off.

Software reads the status byte at the fixed bit positions given below. The interrupt line is the registered OR of the flags that request service. The transmit-empty request is held back while the controller is shifting in a received byte or a read-direction address. Serial shifting, clock generation and address comparison are outside this block.

Top module: `i2c_status_flags`

## Requirements
- R1: After synchronous reset `stat_q` reads 0x80 (only bit 7 set) and `irq` is 0.
- R2: Bit 7 (transmit empty) is cleared by `data_wr` and set by `ev_tx_take` while `en` is 1. When both arrive in the same cycle the write wins and the bit is 0.
- R3: Bit 6 (receive full) is set by `ev_rx_byte` and cleared by `data_rd`. When both arrive in the same cycle the bit ends up 1.
- R4: Bit 5 (address match) is set by `ev_addr_match` only when `slave_mode` is 1 and is cleared by `stat_rd`. A set and a status read in the same cycle leave it 1.
- R5: Bit 4 (general call) is loaded with `addr_is_gc` on every slave-mode `ev_addr_match`, and it is cleared when `en` is 0.
- R6: Bit 3 (read direction) is loaded with `addr_lsb` on every `ev_first_addr`, in either mode, and it is cleared when `en` is 0.
- R7: Bit 2 (arbitration lost) is set by `ev_arb_lost` only when `slave_mode` is 0 and is cleared by `stat_rd`.
- R8: Bit 1 (stop seen) is set by `ev_stop`, bit 0 (NACK seen) by `ev_nack`, and `stat_rd` clears both.
- R9: Every cycle that `en` is 0 returns the status byte to 0x80 on the next edge, and all event strobes are ignored.
- R10: `irq` goes high one cycle after any of bits 6, 5, 2, 1 or 0 is 1, or after bit 7 is 1 while `rx_shift_busy` is 0. Bit 7 alone does not raise `irq` while `rx_shift_busy` is 1. Bits 4 and 3 never raise it.
- R11: `irq` is 0 in the cycle after any cycle in which `en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Controller enable |
| slave_mode | input | 1 | 1 = slave mode, 0 = master mode |
| rx_shift_busy | input | 1 | Shifter is taking in a received byte or a read-direction address |
| data_wr | input | 1 | Software write to the data register |
| data_rd | input | 1 | Software read of the data register |
| stat_rd | input | 1 | Software read of the status register |
| ev_tx_take | input | 1 | Shifter has emptied the data register |
| ev_rx_byte | input | 1 | A complete byte has been received |
| ev_addr_match | input | 1 | Address comparator reports a match |
| addr_is_gc | input | 1 | Qualifies the match as a general call or start byte |
| ev_first_addr | input | 1 | First address byte after START is complete |
| addr_lsb | input | 1 | Direction bit of that address byte |
| ev_arb_lost | input | 1 | Drove SDA high and sampled it low |
| ev_stop | input | 1 | Stop or repeated start observed |
| ev_nack | input | 1 | NACK observed |
| stat_q | output | 8 | Status byte |
| irq | output | 1 | Registered interrupt request |

## Verification
Each flag is driven alone, so a wrong bit position or a wrong clear source shows up as an unexpected byte. Set and clear are then made to collide in one cycle, once for each kind of clear, which separates "set wins" from "clear wins" and shows that a data write beats a transmit take. Mode-gated events are sent in the wrong mode to show that they have no effect. Disable cycles with live strobes show that all flags return to the reset byte and that `irq` stays low. The busy input is toggled against the transmit-empty flag and against the receive-full flag, so the mask is seen to apply to the first and not to the second.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    localparam int STAT_W   = 8;
    localparam int N_STICKY = 5;

    // Field order is the software-visible bit order, MSB first.
    typedef struct packed {
        logic tx_empty;   // [7]
        logic rx_full;    // [6]
        logic addr_hit;   // [5]
        logic gen_call;   // [4]
        logic dir_rd;     // [3]
        logic arb_lost;   // [2]
        logic stop_seen;  // [1]
        logic nack_seen;  // [0]
    } stat_t;

    localparam stat_t STAT_RESET = '{tx_empty: 1'b1, default: 1'b0};

    // Indices into the sticky-flag bank.
    localparam int SK_RXF  = 0;
    localparam int SK_ADDR = 1;
    localparam int SK_ARB  = 2;
    localparam int SK_STOP = 3;
    localparam int SK_NACK = 4;

    function automatic logic any_req(input logic [N_STICKY-1:0] v);
        return |v;
    endfunction

endpackage

// File: rtl/i2c_sticky_flag.sv
module i2c_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || kill)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
        else if (clr)
            q <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set && !kill) |=> q); // R3
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr && !set && !kill) |=> !q); // R8
endmodule

// File: rtl/i2c_irq_gen.sv
module i2c_irq_gen
    import i2c_stat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                tx_empty,
    input  logic                rx_shift_busy,
    input  logic [N_STICKY-1:0] req_vec,
    output logic                irq
);
    logic tx_req;
    assign tx_req = tx_empty && !rx_shift_busy;

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= en && (tx_req || any_req(req_vec));
    end

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> !irq); // R11
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
        (rx_shift_busy && req_vec == '0) |=> !irq); // R10
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
    import i2c_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              slave_mode,
    input  logic              rx_shift_busy,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic              stat_rd,
    input  logic              ev_tx_take,
    input  logic              ev_rx_byte,
    input  logic              ev_addr_match,
    input  logic              addr_is_gc,
    input  logic              ev_first_addr,
    input  logic              addr_lsb,
    input  logic              ev_arb_lost,
    input  logic              ev_stop,
    input  logic              ev_nack,
    output logic [STAT_W-1:0] stat_q,
    output logic              irq
);
    logic [N_STICKY-1:0] sk_set, sk_clr, sk_q;
    logic                tx_empty, gen_call, dir_rd;
    logic                slv_match;
    stat_t               stat;

    assign slv_match = en && slave_mode && ev_addr_match;

    always_comb begin
        sk_set          = '0;
        sk_clr          = '0;
        sk_set[SK_RXF]  = en && ev_rx_byte;
        sk_clr[SK_RXF]  = data_rd;
        sk_set[SK_ADDR] = slv_match;
        sk_clr[SK_ADDR] = stat_rd;
        sk_set[SK_ARB]  = en && !slave_mode && ev_arb_lost;
        sk_clr[SK_ARB]  = stat_rd;
        sk_set[SK_STOP] = en && ev_stop;
        sk_clr[SK_STOP] = stat_rd;
        sk_set[SK_NACK] = en && ev_nack;
        sk_clr[SK_NACK] = stat_rd;
    end

    for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
        i2c_sticky_flag u_flag (
            .clk (clk),
            .rst (rst),
            .kill(!en),
            .set (sk_set[i]),
            .clr (sk_clr[i]),
            .q   (sk_q[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            tx_empty <= 1'b1;
            gen_call <= 1'b0;
            dir_rd   <= 1'b0;
        end else begin
            if (data_wr)
                tx_empty <= 1'b0;
            else if (ev_tx_take)
                tx_empty <= 1'b1;
            if (slv_match)
                gen_call <= addr_is_gc;
            if (ev_first_addr)
                dir_rd <= addr_lsb;
        end
    end

    always_comb begin
        stat           = STAT_RESET;
        stat.tx_empty  = tx_empty;
        stat.rx_full   = sk_q[SK_RXF];
        stat.addr_hit  = sk_q[SK_ADDR];
        stat.gen_call  = gen_call;
        stat.dir_rd    = dir_rd;
        stat.arb_lost  = sk_q[SK_ARB];
        stat.stop_seen = sk_q[SK_STOP];
        stat.nack_seen = sk_q[SK_NACK];
    end

    assign stat_q = stat;

    i2c_irq_gen u_irq (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .tx_empty     (tx_empty),
        .rx_shift_busy(rx_shift_busy),
        .req_vec      (sk_q),
        .irq          (irq)
    );

    AST_OFF_STATE: assert property (@(posedge clk) disable iff (rst)
        !en |=> (stat_q == 8'h80)); // R9
    AST_TX_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (en && data_wr) |=> !stat_q[7]); // R2
    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (en && ev_first_addr) |=> (stat_q[3] == $past(addr_lsb))); // R6
    AST_ARB_MASTER_ONLY: assert property (@(posedge clk) disable iff (rst)
        (en && slave_mode && !stat_q[2]) |=> !stat_q[2]); // R7
endmodule

// File: tb/i2c_status_flags_test.sv
module i2c_status_flags_test;

    localparam int B_EN = 0, B_SLV = 1, B_BUSY = 2, B_DWR = 3, B_DRD = 4,
                   B_SRD = 5, B_TAKE = 6, B_RXB = 7, B_AM = 8, B_GC = 9,
                   B_FA = 10, B_LSB = 11, B_ARB = 12, B_STOP = 13, B_NACK = 14;
    localparam logic [14:0] EN = 15'(1 << B_EN), SLV = 15'(1 << B_SLV),
        BUSY = 15'(1 << B_BUSY), DWR = 15'(1 << B_DWR), DRD = 15'(1 << B_DRD),
        SRD = 15'(1 << B_SRD), TAKE = 15'(1 << B_TAKE), RXB = 15'(1 << B_RXB),
        AM = 15'(1 << B_AM), GC = 15'(1 << B_GC), FA = 15'(1 << B_FA),
        LSB = 15'(1 << B_LSB), ARB = 15'(1 << B_ARB), STP = 15'(1 << B_STOP),
        NCK = 15'(1 << B_NACK);

    typedef struct {
        logic [7:0] stat;
        logic       irq;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] drv = '0;
    logic [7:0]  stat_q;
    logic        irq;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;
    exp_t        sb[$];

    always #2 clk = ~clk;

    i2c_status_flags uut (
        .clk(clk), .rst(rst),
        .en(drv[B_EN]), .slave_mode(drv[B_SLV]), .rx_shift_busy(drv[B_BUSY]),
        .data_wr(drv[B_DWR]), .data_rd(drv[B_DRD]), .stat_rd(drv[B_SRD]),
        .ev_tx_take(drv[B_TAKE]), .ev_rx_byte(drv[B_RXB]),
        .ev_addr_match(drv[B_AM]), .addr_is_gc(drv[B_GC]),
        .ev_first_addr(drv[B_FA]), .addr_lsb(drv[B_LSB]),
        .ev_arb_lost(drv[B_ARB]), .ev_stop(drv[B_STOP]), .ev_nack(drv[B_NACK]),
        .stat_q(stat_q), .irq(irq)
    );

    // Driver: applies one cycle of inputs and queues the result due after the next edge.
    task automatic step(input logic [14:0] v, input logic [7:0] es,
                        input logic ei, input string tag);
        exp_t e;
        drv = v;
        e.stat = es; e.irq = ei; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compares one queued item just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (stat_q !== e.stat || irq !== e.irq) begin
                    n_fail++;
                    $display("FAIL %s: stat=%h irq=%b expected stat=%h irq=%b",
                             e.tag, stat_q, irq, e.stat, e.irq);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(15'd0,                    8'h80, 1'b0, "R1 reset state");
        step(EN,                       8'h80, 1'b1, "R10 tx empty requests irq");
        step(EN|BUSY,                  8'h80, 1'b0, "R10 tx request masked while busy");
        step(EN|DWR,                   8'h00, 1'b1, "R2 data write clears tx empty");
        step(EN,                       8'h00, 1'b0, "R2 stays clear");
        step(EN|TAKE|DWR,              8'h00, 1'b0, "R2 write beats take");
        step(EN|TAKE,                  8'h80, 1'b0, "R2 take sets tx empty");
        step(EN|DWR,                   8'h00, 1'b1, "R2 clear again");
        step(EN|RXB,                   8'h40, 1'b0, "R3 rx byte sets rx full");
        step(EN|BUSY,                  8'h40, 1'b1, "R10 rx full not masked by busy");
        step(EN|DRD|RXB,               8'h40, 1'b1, "R3 set beats data read");
        step(EN|DRD,                   8'h00, 1'b1, "R3 data read clears");
        step(EN,                       8'h00, 1'b0, "R10 irq drops");
        step(EN|AM,                    8'h00, 1'b0, "R4 match ignored in master mode");
        step(EN|SLV|AM|GC,             8'h30, 1'b0, "R4 R5 slave match with general call");
        step(EN|SLV|SRD|AM,            8'h20, 1'b1, "R4 set beats status read, R5 reload");
        step(EN|SLV|SRD,               8'h00, 1'b1, "R4 status read clears");
        step(EN|SLV|FA|LSB,            8'h08, 1'b0, "R6 direction loads 1");
        step(EN|SLV|ARB,               8'h08, 1'b0, "R7 arb lost ignored in slave mode");
        step(EN|ARB,                   8'h0C, 1'b0, "R7 arb lost in master mode");
        step(EN|FA,                    8'h04, 1'b1, "R6 direction loads 0");
        step(EN|SRD,                   8'h00, 1'b1, "R7 status read clears");
        step(EN|STP|NCK,               8'h03, 1'b0, "R8 stop and nack set");
        step(EN|SRD,                   8'h00, 1'b1, "R8 status read clears");
        step(EN|SLV|AM|GC|FA|LSB|RXB,  8'h78, 1'b0, "R5 R6 several flags together");
        step(RXB|NCK,                  8'h80, 1'b0, "R9 disable restores reset byte");
        step(STP|ARB,                  8'h80, 1'b0, "R11 irq low while disabled");
        step(EN|DWR,                   8'h00, 1'b1, "R2 re-enabled write");
        step(EN,                       8'h00, 1'b0, "R10 idle");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule